// File: doc/BRIEF.md
# Encoder Host Command and Status Interface

This block is the register-facing front of a task-based encoding accelerator. Software reaches it over a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and combinational read data. A task is submitted as two consecutive writes to the command address. The first word carries a task identifier, a client identifier and a command type. The second word carries the descriptor address. A validated pair is queued. A stub engine takes queued tasks one at a time, runs them for a fixed latency and posts a status word. When the pair is rejected, the block posts a status word at once instead.

Status words collect in a status FIFO. Software pops them by reading the status address. A fill-level register shows how many words are waiting. Every posted status word raises a level-sensitive status interrupt, which software clears with an acknowledge write. Three memory-interface error registers drive a separate error interrupt. A clock-enable register starts or holds the engine. A read-only register reports a 16-bit identifier. In this stub the error values and the result code of each finished task come in through injection ports.

The command front end has two states. `FR_HEAD` waits for a first word and moves to `FR_DESC` when one is written. `FR_DESC` moves back to `FR_HEAD` on the next command write. The engine has four states:

- `EN_IDLE` goes to `EN_RUN` when a task is queued and the engine-enable bit is set. It goes to `EN_WAIT_GATE` when a task is queued but the bit is clear.
- `EN_WAIT_GATE` goes to `EN_RUN` once the bit is set.
- `EN_RUN` counts the latency down and then goes to `EN_POST`.
- `EN_POST` returns to `EN_IDLE` on the cycle its status word is accepted.

A soft reset sends both machines back to `FR_HEAD` and `EN_IDLE`.

Top module: `enc_host_if`

## Requirements
- R1: After reset both interrupts are low. The fill level, the clock-enable register and the soft-reset-done register read 0. The version register at 0x14C reads the ID parameter in bits [15:0] and 0 above.
- R2: A write to 0x114 when no first word is held is stored as the first word, and it starts nothing. The next write to 0x114 completes the pair. The first word is task[31:16], client[15:8], type[7:0].
- R3: Take a pair with type 0x01, an idle engine and enable bit 0 set. Its status word {task, client, result input} enters the status FIFO at the clock edge LAT+2 edges after the edge that takes the second word. `irq_status` rises on that same edge.
- R4: A pair whose type is not 0x01 is not queued. Status {task, client, 0xF1} is posted at the edge that takes the second word.
- R5: A valid pair that finds the command FIFO holding CMD_DEPTH tasks is dropped. Status {task, client, 0xF0} is posted at that edge.
- R6: While bit 0 of the clock-enable register at 0x148 is clear, queued tasks wait. The engine takes the head task on the edge after the bit is set. Bits [2:0] of that register can be written and read back.
- R7: A read of 0x118 returns the oldest status word and removes it. When the FIFO is empty the read returns 0 and the fill level stays 0. Register 0x11C shows the entry count in bits [3:0].
- R8: Any status push sets `irq_status`. A write to 0x120 with bit 0 set clears it, unless a push happens on the same edge. A write to 0x120 with bit 0 clear has no effect.
- R9: The injection port loads the error register at 0x128 (select 0), 0x12C (select 1) or 0x130 (select 2). `irq_error` is high exactly while any of the three is nonzero. A write to 0x124 with bit 0 set clears all three.
- R10: Any write to 0x100 does the following: it empties both FIFOs, discards a held first word, returns the engine to idle and clears `irq_status`. After that, 0x104 reads 1.
- R11: The engine runs one task at a time in submission order. A status word waiting for a FIFO slot is held unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (pops the status FIFO at 0x118) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_status | output | 1 | Status-posted interrupt |
| irq_error | output | 1 | Memory-interface error interrupt |
| inj_err_we | input | 1 | Load an error register |
| inj_err_sel | input | 2 | Error register select |
| inj_err_val | input | 32 | Value to load |
| inj_result | input | 8 | Result code for a task being posted |

## Verification
Each result has a fixed due cycle:

- A rejected pair (0xF1 or 0xF0) is posted on the same edge that takes the second word.
- An accepted task is posted LAT+2 edges after that edge.
- A task that waited on the enable bit is posted LAT+2 edges after the edge that set the bit.
- A read's data is valid within the cycle of the read strobe, and the pop happens at the following edge.

The bench keeps a behavioural model made of queues and integers. It advances the model on every rising edge and compares both interrupt lines at every falling edge, so an interrupt that arrives one cycle early or late is reported. The R3 check also samples `irq_status` on the falling edges just before and just after the due edge.

// File: rtl/enc_host_pkg.sv
package enc_host_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_SOFT_RST = 12'h100;
    localparam logic [ADDR_W-1:0] A_RST_DONE = 12'h104;
    localparam logic [ADDR_W-1:0] A_CMD      = 12'h114;
    localparam logic [ADDR_W-1:0] A_STS      = 12'h118;
    localparam logic [ADDR_W-1:0] A_FILL     = 12'h11C;
    localparam logic [ADDR_W-1:0] A_IRQ_ACK  = 12'h120;
    localparam logic [ADDR_W-1:0] A_ERR_ACK  = 12'h124;
    localparam logic [ADDR_W-1:0] A_ERR_LOC  = 12'h128;
    localparam logic [ADDR_W-1:0] A_ERR_EXT  = 12'h12C;
    localparam logic [ADDR_W-1:0] A_ERR_SEC  = 12'h130;
    localparam logic [ADDR_W-1:0] A_GATE     = 12'h148;
    localparam logic [ADDR_W-1:0] A_VER      = 12'h14C;

    localparam logic [7:0] CMD_ENCODE    = 8'h01;
    localparam logic [7:0] RC_QUEUE_FULL = 8'hF0;
    localparam logic [7:0] RC_BAD_CMD    = 8'hF1;

    typedef enum logic [0:0] {FR_HEAD, FR_DESC} front_state_t;
    typedef enum logic [1:0] {EN_IDLE, EN_WAIT_GATE, EN_RUN, EN_POST} eng_state_t;

endpackage

// File: rtl/enc_sync_fifo.sv
module enc_sync_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= step(wr_q);
            if (pop)  rd_q <= step(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign dout  = mem_q[rd_q];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/enc_cmd_front.sv
module enc_cmd_front
    import enc_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        cmd_wr,
    input  logic [31:0] wdata,
    input  logic        cmd_full,
    output logic        cmd_push,
    output logic [23:0] cmd_ids,
    output logic        imm_push,
    output logic [31:0] imm_word
);
    front_state_t state_q, state_d;
    logic [31:0]  head_q;
    logic         second, type_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HEAD: if (cmd_wr) state_d = FR_DESC;
            FR_DESC: if (cmd_wr) state_d = FR_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_HEAD;
            head_q  <= '0;
        end else if (flush) begin
            state_q <= FR_HEAD;
        end else begin
            state_q <= state_d;
            if (cmd_wr && state_q == FR_HEAD) head_q <= wdata;
        end
    end

    always_comb begin
        second   = cmd_wr && (state_q == FR_DESC);
        type_ok  = (head_q[7:0] == CMD_ENCODE);
        cmd_ids  = head_q[31:8];
        cmd_push = second && type_ok && !cmd_full;
        imm_push = second && (!type_ok || cmd_full);
        imm_word = {head_q[31:8], type_ok ? RC_QUEUE_FULL : RC_BAD_CMD};
    end

    assert_pair_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push || imm_push) |=> (state_q == FR_HEAD));

endmodule

// File: rtl/enc_task_engine.sv
module enc_task_engine
    import enc_host_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        cmd_avail,
    input  logic [23:0] cmd_ids,
    input  logic        gate_on,
    output logic        cmd_pop,
    output logic        post_req,
    output logic [31:0] post_word,
    input  logic        post_grant,
    input  logic [7:0]  result_code
);
    localparam int CNTW = (LAT > 1) ? $clog2(LAT) : 1;

    eng_state_t      state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [23:0]     ids_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_IDLE:      if (cmd_avail) state_d = gate_on ? EN_RUN : EN_WAIT_GATE;
            EN_WAIT_GATE: if (gate_on)   state_d = EN_RUN;
            EN_RUN:       if (cnt_q == '0) state_d = EN_POST;
            EN_POST:      if (post_grant) state_d = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            cnt_q   <= '0;
            ids_q   <= '0;
        end else if (flush) begin
            state_q <= EN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_pop) begin
                ids_q <= cmd_ids;
                cnt_q <= CNTW'(LAT - 1);
            end else if (state_q == EN_RUN && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        cmd_pop   = (state_q == EN_IDLE || state_q == EN_WAIT_GATE) && cmd_avail && gate_on;
        post_req  = (state_q == EN_POST);
        post_word = {ids_q, result_code};
    end

    assert_post_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (post_req && !post_grant && !flush) |=> (post_req && $stable(post_word[31:8])));
    assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_WAIT_GATE && !gate_on && !flush) |=> (state_q == EN_WAIT_GATE));

endmodule

// File: rtl/enc_host_if.sv
module enc_host_if
    import enc_host_pkg::*;
#(
    parameter int          CMD_DEPTH  = 4,
    parameter int          STS_DEPTH  = 8,
    parameter int          LAT        = 4,
    parameter logic [15:0] VERSION_ID = 16'h0A21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_status,
    output logic              irq_error,
    input  logic              inj_err_we,
    input  logic [1:0]        inj_err_sel,
    input  logic [31:0]       inj_err_val,
    input  logic [7:0]        inj_result
);
    localparam int CCW = $clog2(CMD_DEPTH + 1);
    localparam int SCW = $clog2(STS_DEPTH + 1);

    logic soft_rst, cmd_wr, ack_wr, err_ack_wr;
    logic cmd_push, imm_push, cmd_full, cmd_empty, eng_pop;
    logic [23:0] cmd_ids, cmd_head;
    logic [31:0] imm_word, post_word, sts_din, sts_head, fill_word;
    logic [CCW-1:0] cmd_count;
    logic [SCW-1:0] sts_count;
    logic post_req, post_grant, sts_push, sts_pop, sts_full, sts_empty;
    logic irq_q, done_q;
    logic [2:0]  gate_q;
    logic [31:0] err_q [3];

    assign soft_rst   = bus_we && (bus_addr == A_SOFT_RST);
    assign cmd_wr     = bus_we && (bus_addr == A_CMD);
    assign ack_wr     = bus_we && (bus_addr == A_IRQ_ACK) && bus_wdata[0];
    assign err_ack_wr = bus_we && (bus_addr == A_ERR_ACK) && bus_wdata[0];

    enc_cmd_front u_front (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .cmd_wr(cmd_wr), .wdata(bus_wdata),
        .cmd_full(cmd_full), .cmd_push(cmd_push), .cmd_ids(cmd_ids),
        .imm_push(imm_push), .imm_word(imm_word)
    );

    enc_sync_fifo #(.WIDTH(24), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .push(cmd_push), .din(cmd_ids),
        .pop(eng_pop), .dout(cmd_head), .count(cmd_count), .full(cmd_full), .empty(cmd_empty)
    );

    enc_task_engine #(.LAT(LAT)) u_engine (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .cmd_avail(!cmd_empty), .cmd_ids(cmd_head),
        .gate_on(gate_q[0]), .cmd_pop(eng_pop), .post_req(post_req), .post_word(post_word),
        .post_grant(post_grant), .result_code(inj_result)
    );

    // A rejected pair owns the status FIFO write port; the engine waits a cycle.
    assign post_grant = !imm_push && !sts_full;
    assign sts_push   = (imm_push && !sts_full) || (post_req && post_grant);
    assign sts_din    = imm_push ? imm_word : post_word;
    assign sts_pop    = bus_re && (bus_addr == A_STS) && !sts_empty;

    enc_sync_fifo #(.WIDTH(32), .DEPTH(STS_DEPTH)) u_sts_q (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .push(sts_push), .din(sts_din),
        .pop(sts_pop), .dout(sts_head), .count(sts_count), .full(sts_full), .empty(sts_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            done_q <= 1'b0;
            gate_q <= '0;
            for (int i = 0; i < 3; i++) err_q[i] <= '0;
        end else begin
            if (soft_rst)      irq_q <= 1'b0;
            else if (sts_push) irq_q <= 1'b1;
            else if (ack_wr)   irq_q <= 1'b0;
            if (soft_rst) done_q <= 1'b1;
            if (bus_we && bus_addr == A_GATE) gate_q <= bus_wdata[2:0];
            if (err_ack_wr) for (int i = 0; i < 3; i++) err_q[i] <= '0;
            if (inj_err_we) begin
                case (inj_err_sel)
                    2'd0: err_q[0] <= inj_err_val;
                    2'd1: err_q[1] <= inj_err_val;
                    2'd2: err_q[2] <= inj_err_val;
                    default: ;
                endcase
            end
        end
    end

    assign irq_status = irq_q;
    assign irq_error  = (err_q[0] != '0) || (err_q[1] != '0) || (err_q[2] != '0);
    assign fill_word  = 32'(sts_count) & 32'h0000_000F;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RST_DONE: bus_rdata = {31'b0, done_q};
            A_STS:      bus_rdata = sts_empty ? '0 : sts_head;
            A_FILL:     bus_rdata = fill_word;
            A_ERR_LOC:  bus_rdata = err_q[0];
            A_ERR_EXT:  bus_rdata = err_q[1];
            A_ERR_SEC:  bus_rdata = err_q[2];
            A_GATE:     bus_rdata = {29'b0, gate_q};
            A_VER:      bus_rdata = {16'b0, VERSION_ID};
            default:    bus_rdata = '0;
        endcase
    end

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_push && !soft_rst) |=> irq_status);
    assert_irq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !sts_push) |=> !irq_status);
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ack_wr && !inj_err_we) |=> !irq_error);
    assert_cmd_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_count <= CCW'(CMD_DEPTH));
    assert_soft_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (sts_empty && !irq_status));

endmodule

// File: tb/enc_host_if_tb_top.sv
`timescale 1ns/1ps
module enc_host_if_tb_top;
    import enc_host_pkg::*;

    localparam int CMD_D = 4;
    localparam int STS_D = 8;
    localparam int LAT   = 4;
    localparam logic [15:0] VER = 16'h0A21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] b_addr = '0;
    logic b_we = 1'b0, b_re = 1'b0;
    logic [31:0] b_wd = '0;
    logic [31:0] bus_rdata;
    logic irq_status, irq_error;
    logic inj_we = 1'b0;
    logic [1:0] inj_sel = '0;
    logic [31:0] inj_val = '0;
    logic [7:0] b_res = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    enc_host_if #(.CMD_DEPTH(CMD_D), .STS_DEPTH(STS_D), .LAT(LAT), .VERSION_ID(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we), .bus_re(b_re),
        .bus_wdata(b_wd), .bus_rdata(bus_rdata), .irq_status(irq_status), .irq_error(irq_error),
        .inj_err_we(inj_we), .inj_err_sel(inj_sel), .inj_err_val(inj_val), .inj_result(b_res)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit [23:0] m_cmd[$];
    bit [31:0] m_sts[$];
    int        m_eng, m_cnt;
    bit [23:0] m_ids;
    bit        m_have, m_irq;
    bit [31:0] m_head;
    bit [31:0] m_err[3];
    bit [2:0]  m_gate;

    always @(posedge clk) begin : model
        bit imm, cpush, epop, epush, sfull, pushed;
        bit [31:0] iw, ew;
        bit [23:0] cids;
        int csz;
        imm = 0; cpush = 0; epop = 0; epush = 0; pushed = 0;
        iw = '0; ew = '0; cids = '0;
        if (!rst_n) begin
            m_cmd.delete(); m_sts.delete();
            m_eng = 0; m_cnt = 0; m_ids = '0; m_have = 0; m_irq = 0; m_head = '0;
            m_gate = '0;
            for (int i = 0; i < 3; i++) m_err[i] = '0;
        end else begin
            csz = m_cmd.size();
            sfull = (m_sts.size() >= STS_D);
            if (b_we && b_addr == A_SOFT_RST) begin
                m_cmd.delete(); m_sts.delete();
                m_eng = 0; m_cnt = 0; m_have = 0; m_irq = 0;
            end else begin
                if (b_we && b_addr == A_CMD) begin
                    if (!m_have) begin
                        m_have = 1; m_head = b_wd;
                    end else begin
                        m_have = 0;
                        if (m_head[7:0] != 8'h01) begin imm = 1; iw = {m_head[31:8], 8'hF1}; end
                        else if (csz >= CMD_D)    begin imm = 1; iw = {m_head[31:8], 8'hF0}; end
                        else begin cpush = 1; cids = m_head[31:8]; end
                    end
                end
                case (m_eng)
                    0: if (csz > 0) begin
                           if (m_gate[0]) begin epop = 1; m_eng = 2; m_cnt = LAT - 1; end
                           else m_eng = 1;
                       end
                    1: if (m_gate[0]) begin epop = 1; m_eng = 2; m_cnt = LAT - 1; end
                    2: if (m_cnt == 0) m_eng = 3; else m_cnt--;
                    default: if (!imm && !sfull) begin epush = 1; ew = {m_ids, b_res}; m_eng = 0; end
                endcase
                if (epop) m_ids = m_cmd.pop_front();
                if (cpush) m_cmd.push_back(cids);
                if (b_re && b_addr == A_STS && m_sts.size() > 0) void'(m_sts.pop_front());
                if (imm && !sfull) begin m_sts.push_back(iw); pushed = 1; end
                if (epush) begin m_sts.push_back(ew); pushed = 1; end
                if (b_we && b_addr == A_IRQ_ACK && b_wd[0]) m_irq = 0;
                if (pushed) m_irq = 1;
                if (b_we && b_addr == A_GATE) m_gate = b_wd[2:0];
                if (b_we && b_addr == A_ERR_ACK && b_wd[0])
                    for (int i = 0; i < 3; i++) m_err[i] = '0;
            end
            if (inj_we && inj_sel != 2'd3) m_err[inj_sel] = inj_val;
        end
    end

    // Per-clock comparison of both interrupt lines
    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq_status === m_irq, "R8 irq_status vs model", {31'b0, irq_status}, {31'b0, m_irq});
            chk(irq_error === ((m_err[0] | m_err[1] | m_err[2]) != 0), "R9 irq_error vs model",
                {31'b0, irq_error}, {31'b0, ((m_err[0] | m_err[1] | m_err[2]) != 0)});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        b_we = 1'b1; b_addr = a; b_wd = d;
        @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        b_re = 1'b1; b_addr = a;
        #2;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
        @(negedge clk);
        b_re = 1'b0;
    endtask

    task automatic inject(input logic [1:0] s, input logic [31:0] v);
        inj_we = 1'b1; inj_sel = s; inj_val = v;
        @(negedge clk);
        inj_we = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1 reset state
        rd(A_VER, {16'h0, VER}, "R1 version");
        rd(A_RST_DONE, 32'h0, "R1 reset-done");
        rd(A_FILL, 32'h0, "R1 fill");
        rd(A_GATE, 32'h0, "R1 gate");
        chk(irq_status === 1'b0 && irq_error === 1'b0, "R1 irqs low", {30'b0, irq_status, irq_error}, 32'h0);

        // R3 exact completion timing
        wr(A_GATE, 32'h1);
        b_res = 8'h00;
        wr(A_CMD, 32'h0012_0301);
        wr(A_CMD, 32'h8000_1000);
        waitc(LAT + 1);
        chk(irq_status === 1'b0, "R3 not before due edge", {31'b0, irq_status}, 32'h0);
        waitc(1);
        chk(irq_status === 1'b1, "R3 on due edge", {31'b0, irq_status}, 32'h1);
        rd(A_FILL, 32'h1, "R3 fill");
        rd(A_STS, 32'h0012_0300, "R3 status word");
        rd(A_FILL, 32'h0, "R7 fill after pop");
        wr(A_IRQ_ACK, 32'h0);
        chk(irq_status === 1'b1, "R8 ack bit0 clear ignored", {31'b0, irq_status}, 32'h1);
        wr(A_IRQ_ACK, 32'h1);
        chk(irq_status === 1'b0, "R8 ack clears", {31'b0, irq_status}, 32'h0);

        // R2 lone first word
        b_res = 8'h02;
        wr(A_CMD, 32'h0033_0701);
        waitc(20);
        rd(A_FILL, 32'h0, "R2 lone head starts nothing");
        wr(A_CMD, 32'h4000_0000);
        waitc(LAT + 3);
        rd(A_STS, 32'h0033_0702, "R2 pair completes");
        wr(A_IRQ_ACK, 32'h1);

        // R4 unsupported type
        wr(A_CMD, 32'h0044_0905);
        wr(A_CMD, 32'h0);
        chk(irq_status === 1'b1, "R4 immediate post", {31'b0, irq_status}, 32'h1);
        rd(A_FILL, 32'h1, "R4 fill");
        rd(A_STS, 32'h0044_09F1, "R4 status word");
        wr(A_IRQ_ACK, 32'h1);
        waitc(LAT + 5);
        rd(A_FILL, 32'h0, "R4 not queued");

        // R5 / R6 queue full while gated
        wr(A_GATE, 32'h0);
        for (int i = 1; i <= 5; i++) begin
            wr(A_CMD, {16'(i), 8'(i), 8'h01});
            wr(A_CMD, 32'h0);
        end
        rd(A_FILL, 32'h1, "R5 one drop posted");
        rd(A_STS, 32'h0005_05F0, "R5 queue full word");
        wr(A_IRQ_ACK, 32'h1);
        waitc(30);
        rd(A_FILL, 32'h0, "R6 gated tasks wait");
        b_res = 8'h04;
        wr(A_GATE, 32'h1);
        waitc(4 * (LAT + 3) + 4);
        rd(A_FILL, 32'h4, "R11 all four done");
        for (int i = 1; i <= 4; i++)
            rd(A_STS, {16'(i), 8'(i), 8'h04}, "R11 submission order");
        rd(A_STS, 32'h0, "R7 empty read returns zero");
        rd(A_FILL, 32'h0, "R7 fill stays zero");
        wr(A_IRQ_ACK, 32'h1);
        wr(A_GATE, 32'h7);
        rd(A_GATE, 32'h7, "R6 gate readback");
        wr(A_GATE, 32'h1);

        // R9 error registers
        inject(2'd0, 32'h55);
        inject(2'd2, 32'h1000);
        rd(A_ERR_LOC, 32'h55, "R9 local error reg");
        rd(A_ERR_SEC, 32'h1000, "R9 secondary error reg");
        rd(A_ERR_EXT, 32'h0, "R9 external error reg");
        chk(irq_error === 1'b1, "R9 irq_error high", {31'b0, irq_error}, 32'h1);
        wr(A_ERR_ACK, 32'h0);
        chk(irq_error === 1'b1, "R9 ack bit0 clear ignored", {31'b0, irq_error}, 32'h1);
        wr(A_ERR_ACK, 32'h1);
        chk(irq_error === 1'b0, "R9 ack clears", {31'b0, irq_error}, 32'h0);
        rd(A_ERR_LOC, 32'h0, "R9 cleared reg");

        // R10 soft reset
        wr(A_GATE, 32'h0);
        wr(A_CMD, 32'h0066_0101);
        wr(A_CMD, 32'h0);
        wr(A_CMD, 32'h0077_0101);
        wr(A_SOFT_RST, 32'h1);
        rd(A_RST_DONE, 32'h1, "R10 reset done");
        wr(A_GATE, 32'h1);
        waitc(LAT + 6);
        rd(A_FILL, 32'h0, "R10 queue flushed");
        chk(irq_status === 1'b0, "R10 irq clear", {31'b0, irq_status}, 32'h0);
        wr(A_CMD, 32'h0088_0201);
        wr(A_CMD, 32'h0);
        waitc(LAT + 3);
        rd(A_STS, 32'h0088_0204, "R10 held head discarded");

        waitc(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule